// File: doc/BRIEF.md
# DMA Bus Cycle Sequencer

This block generates one bus-master memory cycle for each word that a DMA engine moves. A request starts a cycle. The sequencer spends one cycle in an address phase (T1) and then stays in a data phase (T2). It inserts between zero and three extra T2 states, chosen by a 2-bit wait field. After those states it keeps extending T2 until the memory's ready line is seen asserted. When the cycle ends, the block returns the read data and gives a single-cycle completion pulse.

A mode bit selects how the ready line is treated. In the asynchronous setting, ready passes through a two-flop synchronizer before it is used, so it can come from a domain with no timing relation to the clock. In the synchronous setting, ready is used directly and must meet setup and hold at the rising clock edge. Direction, address, write data, wait field and mode are all captured when a request is accepted. They then hold for the whole cycle.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bus_t1`, `bus_rd` and `bus_wr` are all 0.
- R2: A request seen high at a rising edge while idle is accepted. `bus_t1` is then high for exactly one cycle, followed by at least one T2 cycle.
- R3: Wait field value W (00=0, 01=1, 10=2, 11=3) adds W extra T2 states. With ready already asserted, the cycle ends at edge a+2+W, where a is the acceptance edge.
- R4: With mode bit 1 (synchronous), ready is used at the same rising edge it is sampled. The cycle ends at the first edge at or after a+2+W where ready is high.
- R5: With mode bit 0 (asynchronous), ready is used two rising edges after it is sampled. A rise of ready before edge r first allows completion at edge r+2.
- R6: `done` is high for exactly one cycle, which is the cycle after the final T2 and has `busy` low. On a read, `rdata` is loaded from `bus_rdata` at the final edge.
- R7: While busy, exactly one of `bus_rd`/`bus_wr` is high, matching the captured direction (1 = write). `bus_addr` stays constant after T1, and on a write `bus_wdata` carries the captured data.
- R8: A request held high while busy is not accepted until the block is idle. It is then accepted at the edge that ends the `done` cycle.
- R9: Changes on `wr`, `addr`, `wdata`, `wait_cnt` or `sync_mode` after acceptance have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a bus cycle |
| wr | input | 1 | Direction, 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| wait_cnt | input | WCW | Extra T2 states to insert |
| sync_mode | input | 1 | 1 = ready synchronous, 0 = ready synchronized internally |
| rdy | input | 1 | Memory ready |
| bus_rdata | input | DW | Data returned by memory |
| bus_t1 | output | 1 | High during the address phase |
| bus_rd | output | 1 | Read strobe for the whole cycle |
| bus_wr | output | 1 | Write strobe for the whole cycle |
| bus_addr | output | AW | Address to memory |
| bus_wdata | output | DW | Data to memory |
| rdata | output | DW | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A cycle is in progress |

## Verification
Every result of this block is a `done` pulse, so each expected item carries the edge at which the pulse must be seen. That edge is max(a+2+W, a+D) in synchronous mode and max(a+2+W, a+D+2) in asynchronous mode. Here a is the acceptance edge and D is the number of edges for which ready was held low. The bench drives inputs on falling edges and keeps an edge counter. The monitor samples at each falling edge and compares the counter at the moment `done` appears with the expected edge. A pulse arriving one edge early or late is therefore reported. Read data and the write data observed on the bus are compared in that same sample.

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [WCW-1:0] wait_cnt,
  input  logic           sync_mode,
  input  logic           rdy,
  input  logic [DW-1:0]  bus_rdata,
  output logic           bus_t1,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  rdata,
  output logic           done,
  output logic           busy
);
  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2} st_t;

  st_t            st;
  logic [WCW-1:0] cnt;
  logic           wr_q, sync_q;
  logic [1:0]     rsync;
  logic           rdy_eff, last;

  always_ff @(posedge clk) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], rdy};
  end

  assign rdy_eff = sync_q ? rdy : rsync[1];
  assign last    = (st == S_T2) && (cnt == '0) && rdy_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      sync_q    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st        <= S_T1;
          cnt       <= wait_cnt;
          wr_q      <= wr;
          sync_q    <= sync_mode;
          bus_addr  <= addr;
          bus_wdata <= wdata;
        end
        S_T1: st <= S_T2;
        S_T2: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (last) begin
            st   <= S_IDLE;
            done <= 1'b1;
            if (!wr_q) rdata <= bus_rdata;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign bus_t1 = (st == S_T1);
  assign bus_rd = busy & ~wr_q;
  assign bus_wr = busy & wr_q;
endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          busy,
  input logic          done,
  input logic          bus_t1,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr
);
  // R2
  t1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_t1 |=> (busy && !bus_t1));

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> bus_t1);

  // R8
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !bus_t1);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  strobe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_rd != bus_wr));

  // R1
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr && !bus_t1));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_t1) |-> $stable(bus_addr));
endmodule

bind dma_cycle_seq dma_cycle_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .bus_t1(bus_t1), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/sim_dma_cycle_seq.sv
`timescale 1ns/1ps
module sim_dma_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n, req, wr, sync_mode, rdy;
  logic [15:0] addr, wdata, bus_rdata;
  logic [1:0]  wait_cnt;
  logic        bus_t1, bus_rd, bus_wr, done, busy;
  logic [15:0] bus_addr, bus_wdata, rdata;

  always #2.5 clk = ~clk;

  dma_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .wait_cnt(wait_cnt), .sync_mode(sync_mode), .rdy(rdy), .bus_rdata(bus_rdata),
    .bus_t1(bus_t1), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rdata(rdata), .done(done), .busy(busy)
  );

  assign bus_rdata = bus_addr ^ 16'h5A3C;

  typedef struct {
    logic        w;
    logic [15:0] data;
    int          edge_no;
    string       tag;
  } item_t;

  item_t       q[$];
  int          cyc = 0;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] last_w = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_wr) last_w = bus_wdata;
    if (rst_n && done) begin
      if (q.size() == 0) check(1'b0, "R6", "unexpected done", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        check(cyc == it.edge_no, it.tag, "done edge", cyc, it.edge_no);
        check(!busy, "R6", "busy during done", busy, 0);
        if (it.w) check(last_w == it.data, it.tag, "write data", last_w, it.data);
        else      check(rdata == it.data, it.tag, "read data", rdata, it.data);
      end
    end
  end

  function automatic int max2(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  function automatic int due(input int a, input int w, input bit m, input int d);
    return max2(a + 2 + w, a + d + (m ? 0 : 2));
  endfunction

  task automatic xfer(input bit w, input logic [15:0] ad, input logic [15:0] wd,
                      input int wc, input bit m, input int d, input string tag,
                      input bit scramble);
    int    a;
    item_t it;
    @(negedge clk);
    req = 1'b1; wr = w; addr = ad; wdata = wd;
    wait_cnt = wc[1:0]; sync_mode = m; rdy = (d == 0);
    a = cyc + 1;
    it.w = w; it.data = w ? wd : (ad ^ 16'h5A3C);
    it.edge_no = due(a, wc, m, d); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req = 1'b0;
    if (scramble) begin
      wr = ~w; addr = ~ad; wdata = ~wd; wait_cnt = 2'b11; sync_mode = ~m;
    end
    for (int i = 1; i < d; i++) @(negedge clk);
    rdy = 1'b1;
    while (q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", "timeout", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    wait_cnt = '0; sync_mode = 1'b1; rdy = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    check(!bus_t1 && !bus_rd && !bus_wr, "R1", "strobes after reset",
          {bus_t1, bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    xfer(1'b0, 16'h0010, 16'h0,    0, 1'b1, 0, "R2/R3 read W0 sync", 1'b0);
    xfer(1'b0, 16'h0123, 16'h0,    3, 1'b1, 0, "R3 read W3 sync", 1'b0);
    xfer(1'b1, 16'h0200, 16'hBEEF, 1, 1'b1, 0, "R3/R7 write W1 sync", 1'b0);
    xfer(1'b0, 16'h0300, 16'h0,    2, 1'b1, 0, "R3 read W2 sync", 1'b0);
    xfer(1'b0, 16'h0444, 16'h0,    0, 1'b1, 4, "R4 read ready late sync", 1'b0);
    xfer(1'b1, 16'h0555, 16'h1234, 1, 1'b1, 2, "R4 write ready at wait end", 1'b0);
    xfer(1'b0, 16'h0666, 16'h0,    2, 1'b0, 0, "R5 read W2 async", 1'b0);
    xfer(1'b0, 16'h0777, 16'h0,    0, 1'b0, 3, "R5 read ready late async", 1'b0);
    xfer(1'b0, 16'h0888, 16'h0,    3, 1'b0, 1, "R5 read W3 hides sync delay", 1'b0);
    xfer(1'b1, 16'h0999, 16'hCAFE, 1, 1'b0, 4, "R5/R7 write late async", 1'b0);
    xfer(1'b0, 16'h0ABC, 16'h0,    0, 1'b1, 0, "R9 inputs changed after accept", 1'b1);
    xfer(1'b1, 16'h0DEF, 16'h7777, 0, 1'b0, 1, "R9 write inputs changed", 1'b1);

    // R8: request held through a busy cycle
    begin
      int    a1, e1, a2;
      item_t it;
      @(negedge clk);
      req = 1'b1; wr = 1'b0; addr = 16'h0F0F; wait_cnt = 2'd1; sync_mode = 1'b1; rdy = 1'b1;
      a1 = cyc + 1;
      e1 = due(a1, 1, 1'b1, 0);
      a2 = e1 + 1;
      it.w = 1'b0; it.data = 16'h0F0F ^ 16'h5A3C; it.tag = "R8 first";
      it.edge_no = e1; q.push_back(it);
      it.tag = "R8 held request"; it.edge_no = due(a2, 1, 1'b1, 0); q.push_back(it);
      while (cyc < a2) @(negedge clk);
      req = 1'b0;
      while (q.size() != 0 || busy) @(negedge clk);
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule